// File: doc/BRIEF.md
# Motor speed lock sequencer

This block brings a DC capstan motor up to a reference speed and holds it there. A 32768 Hz crystal tick is divided down to a reference pulse train whose rate depends on a two-level speed select. The tachometer input from the motor's frequency generator (FG) is synchronized and shaped into one single-cycle pulse per rising edge. A frequency comparator then reports whether the motor is running too slow or too fast. A mode controller picks one of four drive modes: full acceleration, stop/brake, fine acceleration, or phase-locked pulse-width drive.

The stop and acceleration decisions are not taken when the comparator reports. They are taken on three staggered single-cycle strobes that follow each reference pulse, so the whole decision path moves in step with the reference. After reset or a speed change, the sequencer stays in full acceleration until the motor first overshoots the reference. This carries the motor past low-speed points where the FG and reference pulses happen to alternate. The locked flag rises only after a run of reference periods with no verdict.

Top module: `speed_lock_seq`

## Requirements
- R1: The reference pulse comes once every 64 `xtal_tick` pulses when `spd_hi` is 1, and once every 128 when it is 0. The motor therefore locks at an FG period of 64 or 128 ticks.
- R2: `fg_raw` passes through a two-flop synchronizer and is shaped into one pulse per rising edge. In lock, `drv_pwm` falls exactly 4 clock cycles after `fg_raw` rises. No high run of `drv_pwm` is longer than one reference period.
- R3: A slow verdict means two reference pulses arrived with no FG pulse between them. A slow verdict sets `drv_accel` = 1 on the first strobe after the next reference pulse, and acceleration takes priority over stop.
- R4: A fast verdict means two FG pulses arrived with no reference pulse between them. A fast verdict with no slow verdict in the same period sets `drv_stop` = 1 on the second strobe.
- R5: With no verdict in a period, no chase pending and `locked` = 0, the block is in fine acceleration: `drv_pwm` = 1 continuously, and `drv_accel` = `drv_stop` = 0.
- R6: `locked` rises at the third strobe after 8 consecutive quiet periods in fine mode. While locked, `drv_pwm` goes high at each reference pulse and low at the next FG pulse.
- R7: Any verdict clears `locked` at the next third strobe. A change of `spd_hi` clears `locked` and sets `drv_accel` = 1 in the very next cycle.
- R8: After reset or a speed change, `drv_accel` stays 1 even while no slow verdict occurs, until the first fast verdict.
- R9: The acceleration state changes only on the first strobe, the stop state only on the second, and `locked` rises only on the third (reset and speed change excepted). As a result, at a fixed speed, changes of `drv_accel` are spaced by whole reference periods.
- R10: At most one of `drv_accel`, `drv_stop` and `drv_pwm` is high in any cycle.
- R11: Synchronous active-high reset gives `drv_accel` = 1, `drv_stop` = 0, `drv_pwm` = 0, `locked` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spd_hi | input | 1 | Speed select: 1 = high reference rate, 0 = low |
| xtal_tick | input | 1 | Single-cycle enable at the 32768 Hz crystal rate |
| fg_raw | input | 1 | Raw, asynchronous tachometer signal |
| drv_accel | output | 1 | Full acceleration drive |
| drv_stop | output | 1 | Stop/brake drive |
| drv_pwm | output | 1 | Pulse-width drive enable (fine and lock modes) |
| locked | output | 1 | Motor is phase locked to the reference |

## Verification
The in-RTL assertions check the following every cycle:
- the acceleration, stop and lock state change only on their own strobe;
- the drive outputs are mutually exclusive;
- the reference pulse and its three strobes never overlap;
- the shaped FG pulse lasts one cycle;
- the phase flop moves only on reference and FG pulses;
- a chase is never dropped outside the second strobe.

Only the bench scenarios can show the sequence as a whole. These are: the motor held in acceleration past an FG rate equal to the reference during a chase, the handover from stop through fine drive to lock, lock loss when the FG stops, and locking at the low reference rate.

// File: rtl/spdlk_pkg.sv
`timescale 1ns/1ps
package spdlk_pkg;

    typedef enum logic [1:0] {
        MODE_ACCEL = 2'd0,
        MODE_STOP  = 2'd1,
        MODE_FINE  = 2'd2,
        MODE_LOCK  = 2'd3
    } drive_mode_e;

    typedef struct packed {
        logic ref_p;
        logic t1;
        logic t2;
        logic t3;
    } strobe_t;

    typedef struct packed {
        logic slow;
        logic fast;
    } verdict_t;

    typedef struct packed {
        logic accel;
        logic stop;
        logic pwm;
    } drive_t;

    // Mode to drive pins; lock mode passes the phase flop through.
    function automatic drive_t mode_drive(drive_mode_e m, logic phase);
        drive_t d;
        d = '0;
        case (m)
            MODE_ACCEL: d.accel = 1'b1;
            MODE_STOP:  d.stop  = 1'b1;
            MODE_FINE:  d.pwm   = 1'b1;
            MODE_LOCK:  d.pwm   = phase;
            default:    d       = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/spdlk_refgen.sv
`timescale 1ns/1ps
module spdlk_refgen
    import spdlk_pkg::*;
#(
    parameter int DIV_HI = 64,
    parameter int DIV_LO = 128
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sel_chg,
    input  logic    spd_hi,
    input  logic    xtal_tick,
    output strobe_t st
);
    localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
    localparam int CNT_W   = $clog2(DIV_MAX);
    localparam int N_STB   = 3;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             ref_q;
    logic [N_STB-1:0] stb_q;

    assign limit = spd_hi ? CNT_W'(DIV_HI - 1) : CNT_W'(DIV_LO - 1);

    always_ff @(posedge clk) begin
        if (rst || sel_chg) begin
            cnt   <= '0;
            ref_q <= 1'b0;
        end else begin
            ref_q <= 1'b0;
            if (xtal_tick) begin
                if (cnt == limit) begin
                    cnt   <= '0;
                    ref_q <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Staggered decision strobes: one per cycle after the reference pulse.
    always_ff @(posedge clk) begin
        if (rst) stb_q <= '0;
        else     stb_q <= {stb_q[N_STB-2:0], ref_q};
    end

    assign st.ref_p = ref_q;
    assign st.t1    = stb_q[0];
    assign st.t2    = stb_q[1];
    assign st.t3    = stb_q[2];

    // R1
    ref_from_tick_chk: assert property (@(posedge clk) disable iff (rst)
        ref_q |-> $past(xtal_tick));

    // R9
    strobe_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ref_q, stb_q}));

endmodule

// File: rtl/spdlk_fgshape.sv
`timescale 1ns/1ps
module spdlk_fgshape #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fg_raw,
    output logic fg_p
);
    logic [SYNC_N-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
            fg_p   <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], fg_raw};
            last_q <= sync_q[SYNC_N-1];
            fg_p   <= sync_q[SYNC_N-1] & ~last_q;
        end
    end

    // R2
    fg_single_chk: assert property (@(posedge clk) disable iff (rst)
        fg_p |=> !fg_p);

endmodule

// File: rtl/spdlk_freqcmp.sv
`timescale 1ns/1ps
module spdlk_freqcmp
    import spdlk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sel_chg,
    input  logic     ref_p,
    input  logic     fg_p,
    input  logic     clr,
    output verdict_t vlat,
    output logic     phase
);
    logic ref_since;
    logic fg_since;
    logic slow_ev;
    logic fast_ev;

    assign slow_ev = ref_p & ~fg_p & ref_since;
    assign fast_ev = fg_p & ~ref_p & fg_since;

    always_ff @(posedge clk) begin
        if (rst || sel_chg) begin
            ref_since <= 1'b0;
            fg_since  <= 1'b0;
            phase     <= 1'b0;
            vlat      <= '0;
        end else begin
            unique case ({ref_p, fg_p})
                2'b10: begin
                    ref_since <= 1'b1;
                    fg_since  <= 1'b0;
                    phase     <= 1'b1;
                end
                2'b01: begin
                    ref_since <= 1'b0;
                    fg_since  <= 1'b1;
                    phase     <= 1'b0;
                end
                2'b11: begin
                    ref_since <= 1'b0;
                    fg_since  <= 1'b0;
                    phase     <= 1'b0;
                end
                default: ;
            endcase
            vlat.slow <= slow_ev | (vlat.slow & ~clr);
            vlat.fast <= fast_ev | (vlat.fast & ~clr);
        end
    end

    // R6
    phase_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(phase) |-> $past(ref_p));

    // R2
    phase_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(phase) |-> $past(fg_p | sel_chg));

endmodule

// File: rtl/spdlk_modectl.sv
`timescale 1ns/1ps
module spdlk_modectl
    import spdlk_pkg::*;
#(
    parameter int LOCK_N = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sel_chg,
    input  logic     t1,
    input  logic     t2,
    input  logic     t3,
    input  verdict_t v,
    input  logic     phase,
    output drive_t   drv,
    output logic     locked
);
    localparam int Q_W = $clog2(LOCK_N + 1);

    logic           accel_ff;
    logic           stop_ff;
    logic           chase;
    logic [Q_W-1:0] quiet;
    drive_mode_e    mode;

    always_ff @(posedge clk) begin
        if (rst || sel_chg) begin
            accel_ff <= 1'b1;
            stop_ff  <= 1'b0;
            chase    <= 1'b1;
            locked   <= 1'b0;
            quiet    <= '0;
        end else begin
            if (t1) accel_ff <= v.slow | (chase & ~v.fast);
            if (t2) begin
                stop_ff <= v.fast & ~v.slow;
                if (v.fast) chase <= 1'b0;
            end
            if (t3) begin
                if (v.slow || v.fast || accel_ff || stop_ff) begin
                    quiet  <= '0;
                    locked <= 1'b0;
                end else if (quiet == Q_W'(LOCK_N - 1)) begin
                    locked <= 1'b1;
                end else begin
                    quiet <= quiet + 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (accel_ff)     mode = MODE_ACCEL;
        else if (stop_ff) mode = MODE_STOP;
        else if (locked)  mode = MODE_LOCK;
        else              mode = MODE_FINE;
    end

    assign drv = mode_drive(mode, phase);

    // R9
    accel_on_t1_chk: assert property (@(posedge clk) disable iff (rst)
        (accel_ff != $past(accel_ff)) |-> $past(t1 | sel_chg | rst));

    // R9
    stop_on_t2_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_ff != $past(stop_ff)) |-> $past(t2 | sel_chg | rst));

    // R9
    lock_on_t3_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(t3));

    // R8
    chase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (chase && !accel_ff) |-> t2);

    // R10
    drive_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({drv.accel, drv.stop, drv.pwm}));

endmodule

// File: rtl/speed_lock_seq.sv
`timescale 1ns/1ps
module speed_lock_seq
    import spdlk_pkg::*;
#(
    parameter int DIV_HI = 64,
    parameter int DIV_LO = 128,
    parameter int LOCK_N = 8,
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spd_hi,
    input  logic xtal_tick,
    input  logic fg_raw,
    output logic drv_accel,
    output logic drv_stop,
    output logic drv_pwm,
    output logic locked
);
    logic     spd_q;
    logic     sel_chg;
    strobe_t  st;
    logic     fg_p;
    verdict_t vlat;
    logic     phase;
    drive_t   drv;

    always_ff @(posedge clk) spd_q <= spd_hi;
    assign sel_chg = ~rst & (spd_hi ^ spd_q);

    spdlk_refgen #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_ref (
        .clk(clk), .rst(rst), .sel_chg(sel_chg), .spd_hi(spd_hi),
        .xtal_tick(xtal_tick), .st(st)
    );

    spdlk_fgshape #(.SYNC_N(SYNC_N)) u_fg (
        .clk(clk), .rst(rst), .fg_raw(fg_raw), .fg_p(fg_p)
    );

    spdlk_freqcmp u_cmp (
        .clk(clk), .rst(rst), .sel_chg(sel_chg), .ref_p(st.ref_p),
        .fg_p(fg_p), .clr(st.t3), .vlat(vlat), .phase(phase)
    );

    spdlk_modectl #(.LOCK_N(LOCK_N)) u_ctl (
        .clk(clk), .rst(rst), .sel_chg(sel_chg), .t1(st.t1), .t2(st.t2),
        .t3(st.t3), .v(vlat), .phase(phase), .drv(drv), .locked(locked)
    );

    assign drv_accel = drv.accel;
    assign drv_stop  = drv.stop;
    assign drv_pwm   = drv.pwm;

    // R7
    sel_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        sel_chg |=> (!locked && drv_accel));

endmodule

// File: tb/sim_speed_lock_seq.sv
`timescale 1ns/1ps
module sim_speed_lock_seq;

    localparam int PH = 128;   // high-speed reference period in clocks (tick every 2)
    localparam int PL = 256;   // low-speed reference period in clocks

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spd_hi = 1'b1;
    logic xtal_tick = 1'b0;
    logic fg_raw = 1'b0;
    logic drv_accel, drv_stop, drv_pwm, locked;

    int cyc = 0;
    int ncyc = 0;
    int fg_per = 0;
    int fg_ph = 0;
    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        string      req;
        logic [3:0] exp;
        logic [3:0] mask;
    } item_t;
    item_t q[$];

    always #2.5 clk = ~clk;

    speed_lock_seq u0 (
        .clk(clk), .rst(rst), .spd_hi(spd_hi), .xtal_tick(xtal_tick),
        .fg_raw(fg_raw), .drv_accel(drv_accel), .drv_stop(drv_stop),
        .drv_pwm(drv_pwm), .locked(locked)
    );

    // Stimulus generators: crystal tick every other clock, FG square wave.
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        xtal_tick = (cyc % 2 == 0);
        if (fg_per == 0) begin
            fg_raw = 1'b0;
        end else begin
            fg_ph  = (fg_ph + 1) % fg_per;
            fg_raw = (fg_ph < fg_per / 2);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver side of the scoreboard: order {accel, stop, pwm, locked}.
    task automatic expect_out(input string req, input logic [3:0] exp,
                              input logic [3:0] mask);
        item_t it;
        it.req  = req;
        it.exp  = exp;
        it.mask = mask;
        q.push_back(it);
    endtask

    // Monitor state
    logic fg_prev = 1'b0, pwm_prev = 1'b0, lk_prev = 1'b0, acc_prev = 1'b1;
    int   rise_at = 0;
    int   run_len = 0;
    int   r2_falls = 0;
    bit   r2_on = 1'b0;
    bit   r9_on = 1'b0;
    int   last_acc_chg = -1;
    int   excl_bad = 0;

    always @(negedge clk) begin
        logic [3:0] got;
        ncyc = ncyc + 1;
        got = {drv_accel, drv_stop, drv_pwm, locked};
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if ((got & it.mask) !== (it.exp & it.mask)) begin
                n_fail++;
                $display("FAIL %s: accel/stop/pwm/locked got %b expected %b (mask %b)",
                         it.req, got, it.exp, it.mask);
            end
        end
        if (!rst && (drv_accel + drv_stop + drv_pwm > 1)) excl_bad++;
        if (fg_raw && !fg_prev) rise_at = ncyc;
        if (drv_pwm) run_len++;
        // R2 / R6: lock-mode pulse ends exactly 4 cycles after the FG rise
        if (r2_on && locked && lk_prev && pwm_prev && !drv_pwm) begin
            n_chk++;
            r2_falls++;
            if (ncyc - rise_at != 4 || run_len > PH) begin
                n_fail++;
                $display("FAIL R2: pwm fall delay %0d run %0d expected delay 4 run<=%0d",
                         ncyc - rise_at, run_len, PH);
            end
        end
        if (!drv_pwm) run_len = 0;
        // R9: at a fixed high speed, drv_accel changes on the T1 grid
        if (r9_on && (drv_accel != acc_prev)) begin
            if (last_acc_chg >= 0) begin
                n_chk++;
                if ((ncyc - last_acc_chg) % PH != 0) begin
                    n_fail++;
                    $display("FAIL R9: accel change spacing %0d expected multiple of %0d",
                             ncyc - last_acc_chg, PH);
                end
            end
            last_acc_chg = ncyc;
        end
        fg_prev  = fg_raw;
        pwm_prev = drv_pwm;
        lk_prev  = locked;
        acc_prev = drv_accel;
        if (ncyc > 60000) begin
            n_fail++;
            $display("FAIL run: watchdog expired at cycle %0d expected end before 60000", ncyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(6);
        expect_out("R11 reset state", 4'b1000, 4'b1111);
        rst = 1'b0;
        r9_on = 1'b1;

        // FG stopped: slow verdicts every period
        wait_cyc(5 * PH);
        expect_out("R3 slow -> accel", 4'b1000, 4'b1111);

        // FG equal to reference while chasing: accel must hold
        fg_per = PH;
        wait_cyc(10 * PH);
        expect_out("R8 chase holds accel", 4'b1000, 4'b1111);

        // FG more than twice the reference: fast verdict each period
        fg_per = 60;
        wait_cyc(5 * PH);
        expect_out("R4 fast -> stop", 4'b0100, 4'b1111);

        // Back to equal: fine mode, then lock
        fg_per = PH;
        wait_cyc(3 * PH + PH / 2);
        expect_out("R5 fine acceleration", 4'b0010, 4'b1111);
        wait_cyc(10 * PH);
        expect_out("R6 locked at high speed", 4'b0001, 4'b1101);
        r2_on = 1'b1;
        wait_cyc(6 * PH);
        r2_on = 1'b0;
        n_chk++;
        if (r2_falls == 0) begin
            n_fail++;
            $display("FAIL R6: lock-mode pwm pulses seen %0d expected >0", r2_falls);
        end

        // FG stops: verdict clears lock
        fg_per = 0;
        wait_cyc(3 * PH);
        expect_out("R7 verdict clears lock", 4'b1000, 4'b1111);

        // Relock, then change speed
        fg_per = PH;
        wait_cyc(14 * PH);
        expect_out("R6 relocked", 4'b0001, 4'b1101);
        r9_on = 1'b0;
        spd_hi = 1'b0;
        wait_cyc(1);
        expect_out("R7 speed change clears lock", 4'b1000, 4'b1111);

        // Low speed: FG at the old rate is now fast
        wait_cyc(5 * PL);
        expect_out("R1 low speed ref slower -> stop", 4'b0100, 4'b1111);
        fg_per = PL;
        wait_cyc(3 * PL + PL / 2);
        expect_out("R5 fine at low speed", 4'b0010, 4'b1111);
        wait_cyc(12 * PL);
        expect_out("R1 locked at divide-by-128 rate", 4'b0001, 4'b1101);

        // Back to high speed with slow FG, then equal FG: chase holds accel
        spd_hi = 1'b1;
        wait_cyc(4 * PH);
        expect_out("R8 accel after speed up", 4'b1000, 4'b1111);
        fg_per = PH;
        wait_cyc(10 * PH);
        expect_out("R8 chase skips quasi-stable point", 4'b1000, 4'b1111);

        wait_cyc(3);
        n_chk++;
        if (excl_bad != 0) begin
            n_fail++;
            $display("FAIL R10: overlapping drive cycles %0d expected 0", excl_bad);
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule